// File: doc/BRIEF.md
# Bridge Address Window Forwarding Decoder

This block sits beside the target logic on both sides of a two-port bus bridge and decides, for each transaction seen there, whether the bridge should claim it and pass it across. It takes the request address, an I/O or memory flag, the side the request arrived on, and the window and enable settings held in the bridge's configuration space. It answers with a registered claim for the downstream direction, a registered claim for the upstream direction, and a flag that marks a downstream memory claim as prefetchable.

Three windows steer downstream traffic: an I/O range with 4 KB granules, a non-prefetchable memory range with 1 MB granules, and a prefetchable memory range that may reach 64-bit addresses. Decoding is positive, so a downstream claim needs an address inside a window. Two legacy options sit on top of the windows. The ISA option removes the upper three quarters of every 1 KB block below 64 KB from the I/O window. The VGA option always sends the legacy video memory and register ranges downstream. Traffic from the secondary side goes upstream exactly when it misses every downstream range.

Top module: `bwd_fwd_decoder`

## Requirements
- R1: Outputs are registered with one cycle of latency. After a synchronous active-high reset they are 0, and a cycle with `req_valid` low yields all outputs 0 in the next cycle.
- R2: The I/O window covers `{U, cfg_io_base[7:4], 000h}` up to `{V, cfg_io_limit, FFFh}` inclusive, with the address bits above 31 zero. U and V are `cfg_io_base_up` and `cfg_io_limit_up` when `cfg_io_base[3:0]` equals 1; otherwise U and V are 0.
- R3: The memory window covers `{cfg_mem_base, 00000h}` up to `{cfg_mem_limit, FFFFFh}` inclusive, and only for addresses whose bits above 31 are zero.
- R4: The prefetchable window covers `{P, cfg_pf_base[15:4], 00000h}` up to `{Q, cfg_pf_limit, FFFFFh}`. P and Q are the upper-half inputs when `cfg_pf_base[3:0]` equals 1; otherwise they are 0. A downstream memory claim that falls in this window raises `fwd_pref`. Every other claim leaves `fwd_pref` at 0.
- R5: A window whose base field exceeds its limit field matches no address.
- R6: A downstream claim (`req_upstream` = 0) needs `cfg_io_en` for I/O and `cfg_mem_en` for memory. When the needed enable is clear, no claim is made.
- R7: An upstream claim (`req_upstream` = 1) is made exactly when the address misses every downstream range for its kind, including the VGA ranges and after ISA removal, and `cfg_master_en` is set.
- R8: With `cfg_isa_en` set, an I/O address below 10000h whose bits 9:8 are nonzero is removed from the I/O window.
- R9: With `cfg_vga_en` set, memory addresses A0000h to BFFFFh go downstream whatever the windows hold.
- R10: With `cfg_vga_en` set, an I/O address whose low 10 bits lie in 3B0h–3BBh or 3C0h–3DFh goes downstream whatever the windows hold.
- R11: `fwd_down` and `fwd_up` are never both 1, and `fwd_pref` is 1 only together with `fwd_down`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | An address phase is present this cycle |
| req_addr | input | ADDR_W | Request address |
| req_is_io | input | 1 | 1 for an I/O command, 0 for memory |
| req_upstream | input | 1 | 1 when the request arrived on the secondary side |
| cfg_io_base | input | 8 | [7:4] I/O start bits 15:12; [3:0] width code (1 = 32-bit) |
| cfg_io_limit | input | 4 | I/O end bits 15:12 |
| cfg_io_base_up | input | 16 | I/O start bits 31:16 |
| cfg_io_limit_up | input | 16 | I/O end bits 31:16 |
| cfg_mem_base | input | 12 | Memory start bits 31:20 |
| cfg_mem_limit | input | 12 | Memory end bits 31:20 |
| cfg_pf_base | input | 16 | [15:4] prefetchable start bits 31:20; [3:0] width code (1 = 64-bit) |
| cfg_pf_limit | input | 12 | Prefetchable end bits 31:20 |
| cfg_pf_base_up | input | ADDR_W-32 | Prefetchable start upper bits |
| cfg_pf_limit_up | input | ADDR_W-32 | Prefetchable end upper bits |
| cfg_io_en | input | 1 | I/O space enable |
| cfg_mem_en | input | 1 | Memory space enable |
| cfg_master_en | input | 1 | Master enable for upstream forwarding |
| cfg_isa_en | input | 1 | ISA alias removal |
| cfg_vga_en | input | 1 | Legacy video ranges forwarded downstream |
| fwd_down | output | 1 | Claim and forward downstream |
| fwd_up | output | 1 | Claim and forward upstream |
| fwd_pref | output | 1 | Downstream claim is prefetchable |

## Verification
Directed addresses sit exactly on each window's first and last byte and one step past them. This separates inclusive limits from exclusive ones and shows whether the limit granule is filled with ones. Inverted base/limit pairs, cleared enables and the 16-bit versus 32-bit width codes show whether each setting gates the decision it should. Legacy addresses in the ISA-removed quarters, and VGA registers reached through a high alias, show the two overrides apart from the windows. Random settings with addresses biased toward each window then mix the I/O, memory and prefetchable paths in both directions against a reference function.

// File: rtl/bwd_pkg.sv
package bwd_pkg;
  localparam logic [3:0] WIDE_CODE = 4'h1;

  typedef struct packed {
    logic down;
    logic up;
    logic pref;
  } bwd_fwd_t;
endpackage

// File: rtl/bwd_range_cmp.sv
module bwd_range_cmp #(
  parameter int W = 32
) (
  input  logic [W-1:0] addr,
  input  logic [W-1:0] lo,
  input  logic [W-1:0] hi,
  output logic         hit
);
  // an inverted pair (lo above hi) can never match
  always_comb hit = (lo <= hi) && (addr >= lo) && (addr <= hi);
endmodule

// File: rtl/bwd_legacy_dec.sv
module bwd_legacy_dec #(
  parameter int ADDR_W = 64
) (
  input  logic [ADDR_W-17:0] addr_hi,
  input  logic [9:0]         addr_lo10,
  output logic               isa_alias,
  output logic               vga_io,
  output logic               vga_mem
);
  localparam int HW = ADDR_W - 16;

  always_comb begin
    isa_alias = (addr_hi == '0) && (addr_lo10[9:8] != 2'b00);
    vga_io    = ((addr_lo10 >= 10'h3B0) && (addr_lo10 <= 10'h3BB)) ||
                ((addr_lo10 >= 10'h3C0) && (addr_lo10 <= 10'h3DF));
    vga_mem   = (addr_hi == HW'(10)) || (addr_hi == HW'(11));
  end
endmodule

// File: rtl/bwd_fwd_decoder.sv
module bwd_fwd_decoder #(
  parameter int ADDR_W = 64,
  parameter int IO_SH  = 12,
  parameter int MEM_SH = 20
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic                req_is_io,
  input  logic                req_upstream,
  input  logic [7:0]          cfg_io_base,
  input  logic [3:0]          cfg_io_limit,
  input  logic [15:0]         cfg_io_base_up,
  input  logic [15:0]         cfg_io_limit_up,
  input  logic [11:0]         cfg_mem_base,
  input  logic [11:0]         cfg_mem_limit,
  input  logic [15:0]         cfg_pf_base,
  input  logic [11:0]         cfg_pf_limit,
  input  logic [ADDR_W-33:0]  cfg_pf_base_up,
  input  logic [ADDR_W-33:0]  cfg_pf_limit_up,
  input  logic                cfg_io_en,
  input  logic                cfg_mem_en,
  input  logic                cfg_master_en,
  input  logic                cfg_isa_en,
  input  logic                cfg_vga_en,
  output logic                fwd_down,
  output logic                fwd_up,
  output logic                fwd_pref
);
  import bwd_pkg::*;

  localparam int LOW_W = 32;
  localparam int UP_W  = ADDR_W - LOW_W;

  logic              io32, pf64, hi_zero;
  logic [LOW_W-1:0]  io_lo, io_hi;
  logic [LOW_W-1:0]  mem_lo, mem_hi;
  logic [ADDR_W-1:0] pf_lo, pf_hi;
  logic              io_win, mem_win, pf_win;
  logic              isa_alias, vga_io, vga_mem;
  logic              io_claim, mem_claim, down_hit, kind_en;
  bwd_fwd_t          nxt, cur;

  always_comb begin
    io32    = (cfg_io_base[3:0] == WIDE_CODE);
    pf64    = (cfg_pf_base[3:0] == WIDE_CODE);
    hi_zero = (req_addr[ADDR_W-1:LOW_W] == '0);
    io_lo   = {(io32 ? cfg_io_base_up  : 16'h0), cfg_io_base[7:4], {IO_SH{1'b0}}};
    io_hi   = {(io32 ? cfg_io_limit_up : 16'h0), cfg_io_limit,     {IO_SH{1'b1}}};
    mem_lo  = {cfg_mem_base,  {MEM_SH{1'b0}}};
    mem_hi  = {cfg_mem_limit, {MEM_SH{1'b1}}};
    pf_lo   = {(pf64 ? cfg_pf_base_up  : {UP_W{1'b0}}), cfg_pf_base[15:4], {MEM_SH{1'b0}}};
    pf_hi   = {(pf64 ? cfg_pf_limit_up : {UP_W{1'b0}}), cfg_pf_limit,      {MEM_SH{1'b1}}};
  end

  bwd_range_cmp #(.W(LOW_W)) io_cmp_i (
    .addr(req_addr[LOW_W-1:0]), .lo(io_lo), .hi(io_hi), .hit(io_win)
  );

  bwd_range_cmp #(.W(LOW_W)) mem_cmp_i (
    .addr(req_addr[LOW_W-1:0]), .lo(mem_lo), .hi(mem_hi), .hit(mem_win)
  );

  bwd_range_cmp #(.W(ADDR_W)) pf_cmp_i (
    .addr(req_addr), .lo(pf_lo), .hi(pf_hi), .hit(pf_win)
  );

  bwd_legacy_dec #(.ADDR_W(ADDR_W)) legacy_i (
    .addr_hi   (req_addr[ADDR_W-1:16]),
    .addr_lo10 (req_addr[9:0]),
    .isa_alias (isa_alias),
    .vga_io    (vga_io),
    .vga_mem   (vga_mem)
  );

  always_comb begin
    io_claim  = (io_win && hi_zero && !(cfg_isa_en && isa_alias)) ||
                (cfg_vga_en && vga_io);
    mem_claim = (mem_win && hi_zero) || pf_win || (cfg_vga_en && vga_mem);
    down_hit  = req_is_io ? io_claim : mem_claim;
    kind_en   = req_is_io ? cfg_io_en : cfg_mem_en;
    nxt.down  = req_valid && !req_upstream && down_hit && kind_en;
    nxt.up    = req_valid && req_upstream && !down_hit && cfg_master_en;
    nxt.pref  = nxt.down && !req_is_io && pf_win;
  end

  always_ff @(posedge clk) begin
    if (rst) cur <= '0;
    else     cur <= nxt;
  end

  assign fwd_down = cur.down;
  assign fwd_up   = cur.up;
  assign fwd_pref = cur.pref;
endmodule

// File: rtl/bwd_fwd_decoder_chk.sv
module bwd_fwd_decoder_chk #(
  parameter int ADDR_W = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic [ADDR_W-1:0] req_addr,
  input logic              req_is_io,
  input logic              req_upstream,
  input logic              cfg_io_en,
  input logic              cfg_mem_en,
  input logic              cfg_master_en,
  input logic              cfg_vga_en,
  input logic              fwd_down,
  input logic              fwd_up,
  input logic              fwd_pref
);
  logic vga_mem_addr, vga_io_addr;
  always_comb begin
    vga_mem_addr = (req_addr >= ADDR_W'(32'hA0000)) && (req_addr <= ADDR_W'(32'hBFFFF));
    vga_io_addr  = (req_addr[9:0] >= 10'h3C0) && (req_addr[9:0] <= 10'h3DF);
  end

  p_idle_r1: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!fwd_down && !fwd_up && !fwd_pref));

  p_excl_r11: assert property (@(posedge clk) disable iff (rst)
    $onehot0({fwd_down, fwd_up}));

  p_pref_down_r11: assert property (@(posedge clk) disable iff (rst)
    fwd_pref |-> fwd_down);

  p_mem_gate_r6: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_upstream && !req_is_io && !cfg_mem_en) |=> !fwd_down);

  p_io_gate_r6: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_upstream && req_is_io && !cfg_io_en) |=> !fwd_down);

  p_master_gate_r7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_upstream && !cfg_master_en) |=> !fwd_up);

  p_vga_mem_r9: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_upstream && !req_is_io && cfg_mem_en && cfg_vga_en && vga_mem_addr)
      |=> fwd_down);

  p_vga_io_r10: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_upstream && req_is_io && cfg_io_en && cfg_vga_en && vga_io_addr)
      |=> fwd_down);
endmodule

bind bwd_fwd_decoder bwd_fwd_decoder_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
  .req_is_io(req_is_io), .req_upstream(req_upstream),
  .cfg_io_en(cfg_io_en), .cfg_mem_en(cfg_mem_en),
  .cfg_master_en(cfg_master_en), .cfg_vga_en(cfg_vga_en),
  .fwd_down(fwd_down), .fwd_up(fwd_up), .fwd_pref(fwd_pref)
);

// File: tb/bwd_fwd_decoder_tb_top.sv
`timescale 1ns/1ps
module bwd_fwd_decoder_tb_top;
  localparam int AW = 64;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0, req_is_io = 1'b0, req_upstream = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [7:0]  io_base = '0;
  logic [3:0]  io_limit = '0;
  logic [15:0] io_base_up = '0, io_limit_up = '0;
  logic [11:0] mem_base = '0, mem_limit = '0;
  logic [15:0] pf_base = '0;
  logic [11:0] pf_limit = '0;
  logic [31:0] pf_base_up = '0, pf_limit_up = '0;
  logic io_en = 1'b0, mem_en = 1'b0, master_en = 1'b0, isa_en = 1'b0, vga_en = 1'b0;
  logic fwd_down, fwd_up, fwd_pref;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  bwd_fwd_decoder dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_is_io(req_is_io), .req_upstream(req_upstream),
    .cfg_io_base(io_base), .cfg_io_limit(io_limit),
    .cfg_io_base_up(io_base_up), .cfg_io_limit_up(io_limit_up),
    .cfg_mem_base(mem_base), .cfg_mem_limit(mem_limit),
    .cfg_pf_base(pf_base), .cfg_pf_limit(pf_limit),
    .cfg_pf_base_up(pf_base_up), .cfg_pf_limit_up(pf_limit_up),
    .cfg_io_en(io_en), .cfg_mem_en(mem_en), .cfg_master_en(master_en),
    .cfg_isa_en(isa_en), .cfg_vga_en(vga_en),
    .fwd_down(fwd_down), .fwd_up(fwd_up), .fwd_pref(fwd_pref)
  );

  // reference: returns {down, up, pref} from the requirement text
  function automatic logic [2:0] model();
    longint unsigned a = req_addr;
    longint unsigned lo, hi;
    logic hi0 = (a < 64'h1_0000_0000);
    logic in_io, in_mem, in_pf, legacy, hit, en, d, u;
    int unsigned l10 = a % 1024;
    lo = (io_base[3:0] == 4'h1) ? longint'(io_base_up) * 65536 : 0;
    hi = (io_base[3:0] == 4'h1) ? longint'(io_limit_up) * 65536 : 0;
    lo = lo + longint'(io_base[7:4]) * 4096;
    hi = hi + longint'(io_limit) * 4096 + 4095;
    in_io = hi0 && lo <= hi && a >= lo && a <= hi;
    if (isa_en && a < 65536 && ((a / 256) % 4) != 0) in_io = 1'b0;
    lo = longint'(mem_base) * 1048576;
    hi = longint'(mem_limit) * 1048576 + 1048575;
    in_mem = hi0 && lo <= hi && a >= lo && a <= hi;
    lo = longint'(pf_base[15:4]) * 1048576;
    hi = longint'(pf_limit) * 1048576 + 1048575;
    if (pf_base[3:0] == 4'h1) begin
      lo = lo + (longint'(pf_base_up) << 32);
      hi = hi + (longint'(pf_limit_up) << 32);
    end
    in_pf = lo <= hi && a >= lo && a <= hi;
    if (req_is_io) begin
      legacy = vga_en && ((l10 >= 'h3B0 && l10 <= 'h3BB) || (l10 >= 'h3C0 && l10 <= 'h3DF));
      hit = in_io || legacy;
      en = io_en;
    end else begin
      legacy = vga_en && a >= 'hA0000 && a <= 'hBFFFF;
      hit = in_mem || in_pf || legacy;
      en = mem_en;
    end
    d = req_valid && !req_upstream && hit && en;
    u = req_valid && req_upstream && !hit && master_en;
    return {d, u, d && !req_is_io && in_pf};
  endfunction

  task automatic check(input string tag, input logic [2:0] exp);
    checks++;
    if ({fwd_down, fwd_up, fwd_pref} !== exp) begin
      failures++;
      $display("FAIL %s addr=%h got down/up/pref=%b expected=%b",
               tag, req_addr, {fwd_down, fwd_up, fwd_pref}, exp);
    end
  endtask

  // caller is at a negedge; inputs are captured at the next posedge
  task automatic probe(input string tag, input logic io, input logic up,
                       input logic [AW-1:0] a, input logic [2:0] exp);
    logic [2:0] m;
    req_valid = 1'b1; req_is_io = io; req_upstream = up; req_addr = a;
    m = model();
    @(negedge clk);
    check(tag, exp);
    if (m !== exp) begin
      failures++;
      $display("FAIL %s model=%b expected=%b", tag, m, exp);
    end
  endtask

  task automatic base_cfg();
    io_base = 8'h20; io_limit = 4'h3; io_base_up = 16'h0; io_limit_up = 16'h0;
    mem_base = 12'h100; mem_limit = 12'h1FF;
    pf_base = 16'h4001; pf_limit = 12'h4FF; pf_base_up = 32'h1; pf_limit_up = 32'h1;
    io_en = 1; mem_en = 1; master_en = 1; isa_en = 0; vga_en = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED));
    base_cfg();
    req_addr = 64'h2000; req_is_io = 1;
    repeat (3) @(negedge clk);
    check("R1 reset", 3'b000);
    rst = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    check("R1 idle", 3'b000);

    probe("R2 io first byte", 1, 0, 64'h2000, 3'b100);
    probe("R2 io last byte", 1, 0, 64'h3FFF, 3'b100);
    probe("R2 io past limit", 1, 0, 64'h4000, 3'b000);
    probe("R7 io miss upstream", 1, 1, 64'h4000, 3'b010);
    probe("R7 io hit not upstream", 1, 1, 64'h2100, 3'b000);
    probe("R2 io high bits", 1, 0, 64'h1_0000_2000, 3'b000);
    probe("R3 mem last byte", 0, 0, 64'h1FFF_FFFF, 3'b100);
    probe("R3 mem first byte", 0, 0, 64'h1000_0000, 3'b100);
    probe("R3 mem past limit", 0, 0, 64'h2000_0000, 3'b000);
    probe("R3 mem alias above 4G", 0, 0, 64'h2_1000_0000, 3'b000);
    probe("R4 pf 64-bit hit", 0, 0, 64'h1_4000_0000, 3'b101);
    probe("R4 pf last byte", 0, 0, 64'h1_4FFF_FFFF, 3'b101);
    probe("R4 pf low alias", 0, 0, 64'h4000_0000, 3'b000);
    pf_base = 16'h4000;
    probe("R4 pf 32-bit code", 0, 0, 64'h4000_0000, 3'b101);
    pf_base = 16'h4001;
    probe("R7 mem miss upstream", 0, 1, 64'h3000_0000, 3'b010);
    master_en = 0;
    probe("R7 master enable off", 0, 1, 64'h3000_0000, 3'b000);
    master_en = 1;
    mem_base = 12'h300;
    probe("R5 inverted mem down", 0, 0, 64'h1000_0000, 3'b000);
    probe("R5 inverted mem up", 0, 1, 64'h1000_0000, 3'b010);
    mem_base = 12'h100;
    io_base = 8'h50;
    probe("R5 inverted io", 1, 0, 64'h3000, 3'b000);
    io_base = 8'h20;
    mem_en = 0;
    probe("R6 mem enable off", 0, 0, 64'h1000_0000, 3'b000);
    mem_en = 1; io_en = 0;
    probe("R6 io enable off", 1, 0, 64'h2000, 3'b000);
    io_en = 1; isa_en = 1;
    probe("R8 isa removed", 1, 0, 64'h2100, 3'b000);
    probe("R8 isa kept quarter", 1, 0, 64'h2000, 3'b100);
    probe("R8 isa removed goes up", 1, 1, 64'h2300, 3'b010);
    isa_en = 0; vga_en = 1;
    probe("R9 vga mem low", 0, 0, 64'hA0000, 3'b100);
    probe("R9 vga mem high", 0, 0, 64'hBFFFF, 3'b100);
    probe("R9 vga mem past", 0, 0, 64'hC0000, 3'b000);
    probe("R9 vga mem not up", 0, 1, 64'hA8000, 3'b000);
    probe("R10 vga io", 1, 0, 64'h3C5, 3'b100);
    probe("R10 vga io gap", 1, 0, 64'h3BC, 3'b000);
    probe("R10 vga io alias", 1, 0, 64'hF3B0, 3'b100);
    vga_en = 0;
    probe("R10 vga off", 1, 0, 64'h3C5, 3'b000);
    io_base = 8'h21; io_base_up = 16'h1; io_limit_up = 16'h1;
    probe("R2 io 32-bit hit", 1, 0, 64'h1_2000, 3'b100);
    probe("R2 io 32-bit low miss", 1, 0, 64'h2000, 3'b000);

    for (int i = 0; i < 600; i++) begin
      logic [2:0] e;
      io_base = {4'($urandom), ($urandom_range(0, 1) == 1) ? 4'h1 : 4'h0};
      io_limit = 4'($urandom);
      io_base_up = 16'($urandom_range(0, 2)); io_limit_up = 16'($urandom_range(0, 2));
      mem_base = 12'($urandom); mem_limit = 12'($urandom);
      pf_base = {12'($urandom), ($urandom_range(0, 1) == 1) ? 4'h1 : 4'h0};
      pf_limit = 12'($urandom);
      pf_base_up = 32'($urandom_range(0, 1)); pf_limit_up = 32'($urandom_range(0, 1));
      {io_en, mem_en, master_en, isa_en, vga_en} = 5'($urandom);
      req_valid = ($urandom_range(0, 7) != 0);
      req_is_io = 1'($urandom); req_upstream = 1'($urandom);
      case ($urandom_range(0, 3))
        0: req_addr = {32'h0, $urandom};
        1: req_addr = {46'h0, 18'($urandom)};
        2: req_addr = {32'h0, mem_base, 20'($urandom)};
        default: req_addr = {31'h0, 1'($urandom), pf_limit, 20'($urandom)};
      endcase
      e = model();
      @(negedge clk);
      check(req_is_io ? "R2 R7 R8 R10 random io" : "R3 R4 R7 R9 random mem", e);
      checks++;
      if (fwd_down && fwd_up || fwd_pref && !fwd_down) begin
        failures++;
        $display("FAIL R11 got down/up/pref=%b expected exclusive", {fwd_down, fwd_up, fwd_pref});
      end
    end

    req_valid = 0;
    @(negedge clk);
    check("R1 idle end", 3'b000);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule